// File: doc/BRIEF.md
# Receive Destination Address Filter

This block screens incoming Ethernet frames by their 48-bit destination address. The receive path hands it the six address bytes in the order they came off the wire, one per clock when `addr_byte_vld` is high, with `frm_start` marking the first byte of each frame. Once the sixth byte is in, the block produces a one-cycle `verdict_vld` pulse along with `verdict_accept`, which tells the downstream frame logic whether to keep the frame or drop it.

Five paths can accept a frame. Promiscuous mode accepts every frame. The all-ones broadcast address is always accepted. All-multicast mode accepts any group address. Hashed-multicast mode accepts a group address only when its bin is set in a 64-bit bin mask. A unicast frame is accepted when its address exactly equals the programmed station address. The hash bin comes from the top six bits of a CRC-32 that is computed over the address bytes while they stream in, so the block needs no second pass over the address.

Top module: `rx_dest_filter`

## Requirements
- R1: After reset, `verdict_vld` and `verdict_accept` are both 0, and no verdict appears until a full address has been received.
- R2: `verdict_vld` is high for exactly one cycle. That cycle immediately follows the clock cycle that presented the sixth accepted address byte of a frame. Idle cycles with `addr_byte_vld` low may appear between the bytes.
- R3: When promiscuous mode is off, a unicast address (bit 0 of the first byte is 0) is accepted only on an exact 48-bit match with `cfg_station`. The first wire byte is compared with `cfg_station[47:40]`, and so on down to the sixth byte, which is compared with `cfg_station[7:0]`.
- R4: With `cfg_promisc` = 1, every frame is accepted, whatever its address and the other settings.
- R5: The address FF:FF:FF:FF:FF:FF is accepted even with every mode bit 0 and a zero bin mask.
- R6: A group address is one whose first wire byte has bit 0 set. With `cfg_all_mcast` = 1, any group address is accepted, and the bin mask is not consulted.
- R7: With `cfg_hash_mcast` = 1, a non-broadcast group address is accepted exactly when `cfg_bin_mask[n]` is 1. Here n is bits 31:26 of a CRC over the six bytes: the register starts at all ones, the bits of each byte are fed in least significant bit first, the register shifts left, and polynomial 0x04C11DB7 is applied when the shifted-out bit differs from the data bit. No final inversion is applied.
- R8: A non-broadcast group address is rejected when promiscuous, all-multicast and hashed-multicast modes are all off.
- R9: A `frm_start` pulse throws away any partly collected address. A byte presented in the same cycle as `frm_start` counts as the first byte of the new frame.
- R10: Bytes that arrive after the sixth byte and before the next `frm_start` are ignored, and they produce no further verdict.
- R11: `verdict_accept` is 0 whenever `verdict_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frm_start | input | 1 | Marks the first address byte of a new frame |
| addr_byte_vld | input | 1 | Address byte strobe |
| addr_byte | input | 8 | Destination address byte, in wire order |
| cfg_station | input | 48 | Station address; the first wire byte sits in bits 47:40 |
| cfg_bin_mask | input | 64 | Multicast hash bin mask |
| cfg_promisc | input | 1 | Accept every frame |
| cfg_all_mcast | input | 1 | Accept every group address |
| cfg_hash_mcast | input | 1 | Accept group addresses through the bin mask |
| verdict_vld | output | 1 | One-cycle verdict strobe |
| verdict_accept | output | 1 | 1 = keep the frame; qualified by `verdict_vld` |

## Verification
Suppose the byte counter is wrong. Then the verdict pulse appears in the wrong cycle, appears twice, or never appears, and this shows within one frame time of the sixth byte. A corrupted running CRC or a mis-packed address register does not affect the pulse timing. It shows only in the accept bit, on the very next verdict, as a hashed group frame sent to the wrong bin or as a station match that fails. For that reason the bench uses masks with a single bin set and single bin cleared, and addresses that differ from the station address in only one byte.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  localparam logic [31:0] RXF_CRC_POLY = 32'h04C11DB7;
  localparam logic [31:0] RXF_CRC_SEED = 32'hFFFF_FFFF;

  // Why a frame was accepted, listed from highest to lowest priority.
  typedef enum logic [2:0] {
    WHY_NONE,
    WHY_PROMISC,
    WHY_BCAST,
    WHY_ALL_GROUP,
    WHY_HASH_BIN,
    WHY_STATION
  } rxf_why_e;

  typedef struct packed {
    logic promisc;
    logic all_mcast;
    logic hash_mcast;
  } rxf_mode_t;

  // Advances the CRC register by one byte, taking the byte's bits
  // least significant first.
  function automatic logic [31:0] rxf_crc_byte(input logic [31:0] cur,
                                               input logic [7:0]  data);
    logic [31:0] r;
    logic        fb;
    r = cur;
    for (int b = 0; b < 8; b++) begin
      fb = r[31] ^ data[b];
      r  = {r[30:0], 1'b0};
      if (fb) r = r ^ RXF_CRC_POLY;
    end
    return r;
  endfunction

endpackage

// File: rtl/rxf_collect.sv
module rxf_collect #(
  parameter int ADDR_BYTES = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    frm_start,
  input  logic                    byte_vld,
  input  logic [7:0]              byte_in,
  output logic [ADDR_BYTES*8-1:0] addr_now,
  output logic [31:0]             crc_now,
  output logic                    last_take
);
  import rxf_pkg::*;

  localparam int ADDR_W = ADDR_BYTES * 8;
  localparam int CNT_W  = $clog2(ADDR_BYTES + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(ADDR_BYTES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ADDR_BYTES - 1);

  logic [CNT_W-1:0]  cnt_q, cnt_base, cnt_d;
  logic [ADDR_W-1:0] addr_q, addr_base;
  logic [31:0]       crc_q, crc_base;
  logic              take;

  // A frame start discards whatever has been collected so far.
  always_comb begin
    cnt_base  = frm_start ? '0 : cnt_q;
    addr_base = frm_start ? '0 : addr_q;
    crc_base  = frm_start ? RXF_CRC_SEED : crc_q;
  end

  assign take      = byte_vld && (cnt_base < CNT_FULL);
  assign last_take = take && (cnt_base == CNT_LAST);

  always_comb begin
    cnt_d    = cnt_base;
    addr_now = addr_base;
    crc_now  = crc_base;
    if (take) begin
      cnt_d    = cnt_base + 1'b1;
      addr_now = {addr_base[ADDR_W-9:0], byte_in};
      crc_now  = rxf_crc_byte(crc_base, byte_in);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= CNT_FULL;
      addr_q <= '0;
      crc_q  <= RXF_CRC_SEED;
    end else begin
      cnt_q  <= cnt_d;
      addr_q <= addr_now;
      crc_q  <= crc_now;
    end
  end

endmodule

// File: rtl/rxf_classify.sv
module rxf_classify #(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_BITS  = 6
) (
  input  logic [ADDR_BYTES*8-1:0]    addr,
  input  logic [31:0]                crc,
  input  logic [ADDR_BYTES*8-1:0]    station,
  input  logic [(1<<HASH_BITS)-1:0]  bin_mask,
  input  rxf_pkg::rxf_mode_t         mode,
  output logic                       is_group,
  output logic                       is_bcast,
  output logic                       station_hit,
  output logic [HASH_BITS-1:0]       bin_idx,
  output logic                       bin_hit,
  output logic                       keep
);
  import rxf_pkg::*;

  localparam int ADDR_W = ADDR_BYTES * 8;

  rxf_why_e why;

  // Bit 0 of the first wire byte marks a group address.
  assign is_group    = addr[ADDR_W-8];
  assign is_bcast    = &addr;
  assign station_hit = (addr == station);
  assign bin_idx     = crc[31 -: HASH_BITS];
  assign bin_hit     = bin_mask[bin_idx];

  always_comb begin
    why = WHY_NONE;
    if (mode.promisc)                       why = WHY_PROMISC;
    else if (is_bcast)                      why = WHY_BCAST;
    else if (is_group && mode.all_mcast)    why = WHY_ALL_GROUP;
    else if (is_group && mode.hash_mcast && bin_hit)
                                            why = WHY_HASH_BIN;
    else if (!is_group && station_hit)      why = WHY_STATION;
  end

  assign keep = (why != WHY_NONE);

endmodule

// File: rtl/rxf_verdict.sv
module rxf_verdict (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic keep,
  output logic vld_q,
  output logic acc_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      acc_q <= 1'b0;
    end else begin
      vld_q <= fire;
      acc_q <= fire & keep;
    end
  end
endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter #(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_BITS  = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          frm_start,
  input  logic                          addr_byte_vld,
  input  logic [7:0]                    addr_byte,
  input  logic [ADDR_BYTES*8-1:0]       cfg_station,
  input  logic [(1<<HASH_BITS)-1:0]     cfg_bin_mask,
  input  logic                          cfg_promisc,
  input  logic                          cfg_all_mcast,
  input  logic                          cfg_hash_mcast,
  output logic                          verdict_vld,
  output logic                          verdict_accept
);
  import rxf_pkg::*;

  localparam int ADDR_W = ADDR_BYTES * 8;

  logic [ADDR_W-1:0]    addr_now;
  logic [31:0]          crc_now;
  logic                 last_take;
  logic                 is_group, is_bcast, station_hit, bin_hit, keep;
  logic [HASH_BITS-1:0] bin_idx;
  rxf_mode_t            mode;

  assign mode = '{promisc: cfg_promisc, all_mcast: cfg_all_mcast,
                  hash_mcast: cfg_hash_mcast};

  rxf_collect #(.ADDR_BYTES(ADDR_BYTES)) u_collect (
    .clk       (clk),
    .rst_n     (rst_n),
    .frm_start (frm_start),
    .byte_vld  (addr_byte_vld),
    .byte_in   (addr_byte),
    .addr_now  (addr_now),
    .crc_now   (crc_now),
    .last_take (last_take)
  );

  rxf_classify #(.ADDR_BYTES(ADDR_BYTES), .HASH_BITS(HASH_BITS)) u_classify (
    .addr        (addr_now),
    .crc         (crc_now),
    .station     (cfg_station),
    .bin_mask    (cfg_bin_mask),
    .mode        (mode),
    .is_group    (is_group),
    .is_bcast    (is_bcast),
    .station_hit (station_hit),
    .bin_idx     (bin_idx),
    .bin_hit     (bin_hit),
    .keep        (keep)
  );

  rxf_verdict u_verdict (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (last_take),
    .keep  (keep),
    .vld_q (verdict_vld),
    .acc_q (verdict_accept)
  );

endmodule

// File: rtl/rxf_filter_chk.sv
module rxf_filter_chk (
  input logic clk,
  input logic rst_n,
  input logic last_take,
  input logic is_group,
  input logic is_bcast,
  input logic station_hit,
  input logic bin_hit,
  input logic cfg_promisc,
  input logic cfg_all_mcast,
  input logic cfg_hash_mcast,
  input logic verdict_vld,
  input logic verdict_accept
);

  p_verdict_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    last_take |=> verdict_vld);

  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !last_take |=> !verdict_vld);

  p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_vld |=> !verdict_vld);

  p_accept_qualified_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !verdict_vld |-> !verdict_accept);

  p_promisc_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (last_take && cfg_promisc) |=> verdict_accept);

  p_bcast_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (last_take && is_bcast) |=> verdict_accept);

  p_all_group_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (last_take && is_group && cfg_all_mcast) |=> verdict_accept);

  p_hash_bin_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (last_take && is_group && !is_bcast && !cfg_promisc && !cfg_all_mcast
     && cfg_hash_mcast) |=> (verdict_accept == $past(bin_hit)));

  p_group_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (last_take && is_group && !is_bcast && !cfg_promisc && !cfg_all_mcast
     && !cfg_hash_mcast) |=> !verdict_accept);

  p_unicast_exact_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (last_take && !is_group && !is_bcast && !cfg_promisc)
    |=> (verdict_accept == $past(station_hit)));

endmodule

bind rx_dest_filter rxf_filter_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .last_take      (last_take),
  .is_group       (is_group),
  .is_bcast       (is_bcast),
  .station_hit    (station_hit),
  .bin_hit        (bin_hit),
  .cfg_promisc    (cfg_promisc),
  .cfg_all_mcast  (cfg_all_mcast),
  .cfg_hash_mcast (cfg_hash_mcast),
  .verdict_vld    (verdict_vld),
  .verdict_accept (verdict_accept)
);

// File: tb/sim_rx_dest_filter.sv
`timescale 1ns/1ps
module sim_rx_dest_filter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frm_start = 1'b0;
  logic        addr_byte_vld = 1'b0;
  logic [7:0]  addr_byte = 8'h00;
  logic [47:0] cfg_station = 48'h0;
  logic [63:0] cfg_bin_mask = 64'h0;
  logic        cfg_promisc = 1'b0;
  logic        cfg_all_mcast = 1'b0;
  logic        cfg_hash_mcast = 1'b0;
  logic        verdict_vld;
  logic        verdict_accept;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  rx_dest_filter u0 (
    .clk            (clk),
    .rst_n          (rst_n),
    .frm_start      (frm_start),
    .addr_byte_vld  (addr_byte_vld),
    .addr_byte      (addr_byte),
    .cfg_station    (cfg_station),
    .cfg_bin_mask   (cfg_bin_mask),
    .cfg_promisc    (cfg_promisc),
    .cfg_all_mcast  (cfg_all_mcast),
    .cfg_hash_mcast (cfg_hash_mcast),
    .verdict_vld    (verdict_vld),
    .verdict_accept (verdict_accept)
  );

  localparam logic [47:0] STATION = 48'h02_11_22_33_44_55;
  localparam logic [47:0] GRP_A   = 48'h01_00_5E_7F_00_09;
  localparam logic [47:0] GRP_B   = 48'h33_33_00_00_00_FB;
  localparam logic [47:0] BCAST   = 48'hFF_FF_FF_FF_FF_FF;

  task automatic check(input string req, input logic [63:0] act,
                       input logic [63:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // The hash bin, computed over a 48-bit serial stream in wire order.
  function automatic logic [5:0] ref_bin(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < 48; i++) begin
      logic d, top;
      d   = a[47 - 8*(i/8) - 7 + (i%8)];
      top = c[31];
      c   = c << 1;
      if (top != d) c = c ^ 32'h04C11DB7;
    end
    return c[31:26];
  endfunction

  function automatic logic ref_keep(input logic [47:0] a);
    logic grp;
    grp = a[40];
    if (cfg_promisc) return 1'b1;
    if (a == BCAST) return 1'b1;
    if (grp) return cfg_all_mcast || (cfg_hash_mcast && cfg_bin_mask[ref_bin(a)]);
    return a == cfg_station;
  endfunction

  // Sends one address and checks the verdict pulse (R2, R11).
  task automatic send_and_check(input string req, input logic [47:0] a,
                                input logic exp_acc, input int gap);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check("R2", verdict_vld, 1'b0, "no verdict before sixth byte");
      frm_start     = (k == 0);
      addr_byte_vld = 1'b1;
      addr_byte     = a[47 - 8*k -: 8];
      for (int g = 0; g < gap && k < 5; g++) begin
        @(negedge clk);
        frm_start     = 1'b0;
        addr_byte_vld = 1'b0;
      end
    end
    @(negedge clk);
    frm_start     = 1'b0;
    addr_byte_vld = 1'b0;
    check("R2", verdict_vld, 1'b1, "verdict after sixth byte");
    check(req, verdict_accept, exp_acc, "accept");
    @(negedge clk);
    check("R2", verdict_vld, 1'b0, "pulse is one cycle");
    check("R11", verdict_accept, 1'b0, "accept low without valid");
  endtask

  task automatic set_mode(input logic p, input logic am, input logic hm,
                          input logic [63:0] m);
    @(negedge clk);
    cfg_promisc = p; cfg_all_mcast = am; cfg_hash_mcast = hm; cfg_bin_mask = m;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1", verdict_vld, 1'b0, "valid after reset");
    check("R1", verdict_accept, 1'b0, "accept after reset");
  endtask

  task automatic t_unicast;
    set_mode(0, 0, 0, 64'h0);
    send_and_check("R3", STATION, 1'b1, 0);
    send_and_check("R3", STATION ^ 48'h01, 1'b0, 0);
    send_and_check("R3", STATION ^ 48'h06_00_00_00_00_00, 1'b0, 2);
    set_mode(0, 1, 1, 64'hFFFF_FFFF_FFFF_FFFF);
    send_and_check("R3", 48'h0A_00_00_00_00_01, 1'b0, 0);
  endtask

  task automatic t_promisc;
    set_mode(1, 0, 0, 64'h0);
    send_and_check("R4", 48'h0A_BC_DE_F0_12_34, 1'b1, 0);
    send_and_check("R4", GRP_A, 1'b1, 1);
  endtask

  task automatic t_bcast;
    set_mode(0, 0, 0, 64'h0);
    send_and_check("R5", BCAST, 1'b1, 0);
  endtask

  task automatic t_all_group;
    set_mode(0, 1, 0, 64'h0);
    send_and_check("R6", GRP_A, 1'b1, 0);
    send_and_check("R6", GRP_B, 1'b1, 0);
  endtask

  task automatic t_hash;
    logic [5:0] ba, bb;
    ba = ref_bin(GRP_A);
    bb = ref_bin(GRP_B);
    set_mode(0, 0, 1, 64'h1 << ba);
    send_and_check("R7", GRP_A, 1'b1, 0);
    set_mode(0, 0, 1, ~(64'h1 << ba));
    send_and_check("R7", GRP_A, 1'b0, 0);
    set_mode(0, 0, 1, 64'h1 << bb);
    send_and_check("R7", GRP_B, 1'b1, 1);
    if (ba != bb) send_and_check("R7", GRP_A, 1'b0, 0);
  endtask

  task automatic t_group_off;
    set_mode(0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF);
    send_and_check("R8", GRP_A, 1'b0, 0);
  endtask

  task automatic t_restart;
    set_mode(0, 0, 0, 64'h0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      frm_start = (k == 0); addr_byte_vld = 1'b1; addr_byte = 8'hA0 + 8'(k);
    end
    @(negedge clk);
    frm_start = 1'b0; addr_byte_vld = 1'b0;
    check("R9", verdict_vld, 1'b0, "no verdict from partial address");
    send_and_check("R9", STATION, 1'b1, 0);
  endtask

  task automatic t_extra;
    set_mode(0, 0, 0, 64'h0);
    send_and_check("R10", STATION, 1'b1, 0);
    for (int k = 0; k < 7; k++) begin
      @(negedge clk);
      check("R10", verdict_vld, 1'b0, "extra bytes make no verdict");
      addr_byte_vld = 1'b1; addr_byte = STATION[47 - 8*(k%6) -: 8];
    end
    @(negedge clk);
    addr_byte_vld = 1'b0;
    check("R10", verdict_vld, 1'b0, "extra bytes make no verdict");
    @(negedge clk);
    check("R10", verdict_vld, 1'b0, "extra bytes make no verdict");
  endtask

  task automatic t_sweep;
    logic [47:0] addrs [4];
    addrs[0] = STATION; addrs[1] = GRP_A; addrs[2] = GRP_B;
    addrs[3] = 48'h0C_00_00_00_00_07;
    for (int m = 0; m < 8; m++) begin
      set_mode(m[2], m[1], m[0], 64'h0F0F_3C3C_A5A5_9669);
      for (int i = 0; i < 4; i++)
        send_and_check("R6", addrs[i], ref_keep(addrs[i]), i % 2);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    cfg_station = STATION;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_unicast();
    t_promisc();
    t_bcast();
    t_all_group();
    t_hash();
    t_group_off();
    t_restart();
    t_extra();
    t_sweep();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule